// File: doc/BRIEF.md
# Grouped Match Timer Channel Array

This block is a bank of eight match-timer channels, numbered 4 to 11 in the status and enable words. Each channel holds a 32-bit counter, a match value and a control word. The control word picks which of five reference tick-enable inputs advances the counter. It also decides whether the channel compares against its own counter or against the counter of the leader of its group, and whether a match clears the counter. A last control bit chooses between firing once and firing again on every later match.

Channels 4 to 7 form one group led by channel 4. Channels 8 and 9 are led by channel 8, and channels 10 and 11 by channel 10. A follower that does not compare against its own counter leaves that counter frozen, so it is a pure extra compare point on its leader's count. A read of the counter of channel 9 or 11 can also capture the counter of channel 8 or 10 into a snapshot register in the same cycle, so software gets a consistent pair of values. Matches that are enabled raise status bits, and any pending status bit drives one shared interrupt line.

Top module: `tmr_match_array`

## Requirements
- R1: Control bits [2:0] select the count source: value k in 1..5 counts on tick_in[k-1] (1 = 32.768 kHz, 2 = 1 kHz, 3 = 1 Hz, 4 = 1 MHz, 5 = external); values 0, 6 and 7 stop the counter. A running counter rises by one on every cycle in which its selected tick is high.
- R2: With control bit 7 set a channel compares against its own counter. With bit 7 clear it compares against its group leader's counter (channel 4 for 4..7, channel 8 for 8..9, channel 10 for 10..11). A match happens in a cycle where the compared counter's tick is high and the compared counter, before the increment, equals the match value.
- R3: A follower channel (bit 7 clear, not a leader) does not advance its own counter.
- R4: With control bit 3 set, a match clears the channel's own counter to 0 in place of the increment.
- R5: With control bit 6 clear a channel fires at most once and then stays quiet until its match or counter register is written; with bit 6 set it fires on every match.
- R6: On channels 8 to 11, control bit 8 stops the counter whatever bits [2:0] hold.
- R7: A control write keeps bits [7:0] on channels 4 to 7 and bits [9:0] on channels 8 to 11; the remaining bits read back as 0.
- R8: A counter read of channel 9 (or 11) whose control bit 9 is set copies channel 8's (or 10's) counter into the snapshot register at offset 0x20; without bit 9 the snapshot is left unchanged.
- R9: A match on channel n sets status bit n (offset 0x14) only when enable bit n (offset 0x1C) is set; writing 1 to a status bit clears it.
- R10: The interrupt output is high while any status bit 4..11 is set and low otherwise. A match and a clear of the same status bit in one cycle leave the bit set.
- R11: A bus write to a counter takes priority over a tick in the same cycle, and it re-arms the channel.
- R12: Counters sit at 0x40 + 4*(n-4), match values at 0x80 + 4*(n-4), control words at 0xC0 + 4*(n-4). Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 5 | Single-cycle tick enables for clock selects 1..5 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; triggers snapshot capture |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Combined interrupt of all eight channels |

## Verification
Two functions can collide in one cycle. A match can raise a status bit in the same cycle in which software writes 1 to clear it, and a tick can try to advance a counter in the same cycle that the bus loads it. The bench provokes both by driving a tick and the bus write together in one cycle, at the exact count where the match falls. It then judges the result at the ports: the status bit must stay set and the irq line high, and the counter must hold the written value with no increment added.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NTICK  = 5;
  localparam int CTL_W  = 10;
  localparam int F_CLR  = 3;
  localparam int F_PER  = 6;
  localparam int F_OWN  = 7;
  localparam int F_STOP = 8;
  localparam int F_SNAP = 9;

  typedef enum logic [1:0] {
    RG_MISC  = 2'd0,
    RG_CNT   = 2'd1,
    RG_MATCH = 2'd2,
    RG_CTRL  = 2'd3
  } region_e;

  // tick chosen by a 3-bit clock select; unused codes give no tick
  function automatic logic tick_for_sel(input logic [2:0] sel, input logic [NTICK-1:0] ticks);
    logic r;
    r = 1'b0;
    for (int k = 0; k < NTICK; k++)
      if (int'(sel) == k + 1) r = ticks[k];
    return r;
  endfunction

  // first half of the bank shares channel 0, the rest pair up on even indices
  function automatic int leader_of(input int idx, input int nch);
    if (idx < nch / 2) return 0;
    return idx - (idx % 2);
  endfunction

  // odd channels in the upper half may capture their leader; -1 = none
  function automatic int snap_src(input int idx, input int nch);
    if (idx >= nch / 2 && (idx % 2) == 1) return idx - 1;
    return -1;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_keep(input int idx, input int nch);
    return (idx < nch / 2) ? 10'h0FF : 10'h3FF;
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int CW  = 32,
  parameter int IDX = 0,
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTICK-1:0] ticks,
  input  logic [CW-1:0]    wdata,
  input  logic             wr_cnt,
  input  logic             wr_match,
  input  logic             wr_ctrl,
  input  logic [CW-1:0]    lead_cnt,
  input  logic             lead_tick,
  output logic [CW-1:0]    cnt,
  output logic [CW-1:0]    match_val,
  output logic [CTL_W-1:0] ctrl,
  output logic             own_tick,
  output logic             hit
);
  localparam bit IS_LEAD  = (leader_of(IDX, NCH) == IDX);
  localparam bit CAN_HALT = (IDX >= NCH / 2);
  localparam logic [CTL_W-1:0] KEEP = ctl_keep(IDX, NCH);

  function automatic logic [CW-1:0] next_count(
    input logic [CW-1:0] cur, input logic load, input logic [CW-1:0] ld_val,
    input logic clr, input logic adv);
    if (load) return ld_val;
    if (clr)  return '0;
    if (adv)  return cur + 1'b1;
    return cur;
  endfunction

  logic            armed_q;
  logic            halted;
  logic            use_own;
  logic [CW-1:0]   cmp_cnt;
  logic            cmp_tick;

  assign halted   = (!ctrl[F_OWN] && !IS_LEAD) || (CAN_HALT && ctrl[F_STOP]);
  assign own_tick = tick_for_sel(ctrl[2:0], ticks) && !halted;
  assign use_own  = ctrl[F_OWN] || IS_LEAD;
  assign cmp_cnt  = use_own ? cnt : lead_cnt;
  assign cmp_tick = use_own ? own_tick : lead_tick;
  assign hit      = armed_q && cmp_tick && (cmp_cnt == match_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      match_val <= '0;
      ctrl      <= '0;
      armed_q   <= 1'b1;
    end else begin
      cnt <= next_count(cnt, wr_cnt, wdata, hit && ctrl[F_CLR], own_tick);
      if (wr_match) match_val <= wdata;
      if (wr_ctrl)  ctrl <= wdata[CTL_W-1:0] & KEEP;
      if (wr_cnt || wr_match)      armed_q <= 1'b1;
      else if (hit && !ctrl[F_PER]) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_evt.sv
module tmr_evt #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           wr_stat,
  input  logic           wr_ier,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] status,
  output logic [NCH-1:0] ier,
  output logic           irq
);
  // new events win over a clear of the same bit
  function automatic logic [NCH-1:0] next_status(
    input logic [NCH-1:0] cur, input logic [NCH-1:0] clr, input logic [NCH-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      ier    <= '0;
    end else begin
      status <= next_status(status, wr_stat ? wbits : '0, hit & ier);
      if (wr_ier) ier <= wbits;
    end
  end

  assign irq = |status;
endmodule

// File: rtl/tmr_match_array.sv
module tmr_match_array
  import tmr_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int CW      = 32,
  parameter int AW      = 8,
  parameter int BASE_ID = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTICK-1:0] tick_in,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [CW-1:0]    bus_wdata,
  output logic [CW-1:0]    bus_rdata,
  output logic             irq
);
  localparam int IW = $clog2(NCH);
  localparam logic [AW-1:0] A_STAT = AW'(8'h14);
  localparam logic [AW-1:0] A_IER  = AW'(8'h1C);
  localparam logic [AW-1:0] A_SNAP = AW'(8'h20);

  region_e        region;
  logic           addr_ok;
  logic           bank_ok;
  logic [IW-1:0]  sel_ch;

  assign region  = region_e'(bus_addr[7:6]);
  assign addr_ok = ((bus_addr >> 8) == '0);
  assign bank_ok = addr_ok && !bus_addr[5] && (bus_addr[1:0] == 2'b00);
  assign sel_ch  = bus_addr[2 +: IW];

  logic [CW-1:0]    cnt_a      [NCH];
  logic [CW-1:0]    match_a    [NCH];
  logic [CTL_W-1:0] ctrl_a     [NCH];
  logic             own_tick_a [NCH];
  logic [CW-1:0]    snap_src_a [NCH];

  // named per-channel events for the checker
  logic [NCH-1:0]    hit_v, wr_cnt_v, wr_match_v, wr_ctrl_v, rd_cnt_v, snap_req_v;
  logic [NCH-1:0]    b3_v, b6_v, b7_v, b8_v, status_v, ier_v;
  logic [NCH*CW-1:0] cnt_flat;
  logic [CW-1:0]     snap_q;

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_ch
      localparam int LEAD = leader_of(i, NCH);
      localparam int SRC  = snap_src(i, NCH);

      assign wr_cnt_v[i]   = bus_wr && bank_ok && region == RG_CNT   && sel_ch == IW'(i);
      assign wr_match_v[i] = bus_wr && bank_ok && region == RG_MATCH && sel_ch == IW'(i);
      assign wr_ctrl_v[i]  = bus_wr && bank_ok && region == RG_CTRL  && sel_ch == IW'(i);
      assign rd_cnt_v[i]   = bus_rd && bank_ok && region == RG_CNT   && sel_ch == IW'(i);

      tmr_chan #(.CW(CW), .IDX(i), .NCH(NCH)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .ticks     (tick_in),
        .wdata     (bus_wdata),
        .wr_cnt    (wr_cnt_v[i]),
        .wr_match  (wr_match_v[i]),
        .wr_ctrl   (wr_ctrl_v[i]),
        .lead_cnt  (cnt_a[LEAD]),
        .lead_tick (own_tick_a[LEAD]),
        .cnt       (cnt_a[i]),
        .match_val (match_a[i]),
        .ctrl      (ctrl_a[i]),
        .own_tick  (own_tick_a[i]),
        .hit       (hit_v[i])
      );

      assign b3_v[i] = ctrl_a[i][F_CLR];
      assign b6_v[i] = ctrl_a[i][F_PER];
      assign b7_v[i] = ctrl_a[i][F_OWN];
      assign b8_v[i] = ctrl_a[i][F_STOP];
      assign cnt_flat[i*CW +: CW] = cnt_a[i];

      if (SRC >= 0) begin : g_snap
        assign snap_req_v[i] = rd_cnt_v[i] && ctrl_a[i][F_SNAP];
        assign snap_src_a[i] = cnt_a[SRC];
      end else begin : g_nosnap
        assign snap_req_v[i] = 1'b0;
        assign snap_src_a[i] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) snap_q <= '0;
    else
      for (int k = 0; k < NCH; k++)
        if (snap_req_v[k]) snap_q <= snap_src_a[k];
  end

  tmr_evt #(.NCH(NCH)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit_v),
    .wr_stat (bus_wr && bus_addr == A_STAT),
    .wr_ier  (bus_wr && bus_addr == A_IER),
    .wbits   (bus_wdata[BASE_ID +: NCH]),
    .status  (status_v),
    .ier     (ier_v),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      unique case (region)
        RG_MISC: begin
          if (bus_addr == A_STAT)      bus_rdata[BASE_ID +: NCH] = status_v;
          else if (bus_addr == A_IER)  bus_rdata[BASE_ID +: NCH] = ier_v;
          else if (bus_addr == A_SNAP) bus_rdata = snap_q;
        end
        RG_CNT:   if (bank_ok) bus_rdata = cnt_a[sel_ch];
        RG_MATCH: if (bank_ok) bus_rdata = match_a[sel_ch];
        RG_CTRL:  if (bank_ok) bus_rdata = CW'(ctrl_a[sel_ch]);
        default:  bus_rdata = '0;
      endcase
    end
  end

  logic unused_sink;
  always_comb begin
    unused_sink = 1'b0;
    for (int k = 0; k < NCH; k++)
      unused_sink = unused_sink ^ (^ctrl_a[k]) ^ own_tick_a[k];
  end
endmodule

// File: rtl/tmr_match_array_chk.sv
module tmr_match_array_chk #(
  parameter int NCH = 8,
  parameter int CW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              irq,
  input logic [NCH-1:0]    hit_v,
  input logic [NCH-1:0]    ier_v,
  input logic [NCH-1:0]    status_v,
  input logic [NCH-1:0]    b3_v,
  input logic [NCH-1:0]    b6_v,
  input logic [NCH-1:0]    b7_v,
  input logic [NCH-1:0]    b8_v,
  input logic [NCH-1:0]    wr_cnt_v,
  input logic [NCH-1:0]    wr_match_v,
  input logic [NCH*CW-1:0] cnt_flat
);
  import tmr_pkg::*;

  // R9: an enabled match shows up in status on the next cycle
  p_set_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit_v & ier_v)) |=> ((status_v & $past(hit_v & ier_v)) == $past(hit_v & ier_v)));

  // R9: no status bit rises without an enabled match before it
  p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_v & ~$past(status_v) & ~$past(hit_v & ier_v)) == '0));

  // R10: the interrupt only drops after a bus write
  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_wr));

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_chk
      // R5: a one-shot channel does not fire on the following cycle
      p_oneshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v[i] && !b6_v[i] && !wr_cnt_v[i] && !wr_match_v[i]) |=> !hit_v[i]);

      if (leader_of(i, NCH) != i) begin : g_fol
        // R3: a follower's own counter stays put
        p_follower_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
          (!b7_v[i] && !wr_cnt_v[i] && !(hit_v[i] && b3_v[i]))
          |=> $stable(cnt_flat[i*CW +: CW]));
      end
      if (i >= NCH / 2) begin : g_halt
        // R6: forced stop freezes the counter
        p_force_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (b8_v[i] && !wr_cnt_v[i] && !(hit_v[i] && b3_v[i]))
          |=> $stable(cnt_flat[i*CW +: CW]));
      end
    end
  endgenerate

  logic unused_sink;
  assign unused_sink = ^b8_v;
endmodule

bind tmr_match_array tmr_match_array_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .irq        (irq),
  .hit_v      (hit_v),
  .ier_v      (ier_v),
  .status_v   (status_v),
  .b3_v       (b3_v),
  .b6_v       (b6_v),
  .b7_v       (b7_v),
  .b8_v       (b8_v),
  .wr_cnt_v   (wr_cnt_v),
  .wr_match_v (wr_match_v),
  .cnt_flat   (cnt_flat)
);

// File: tb/tmr_match_array_tb_top.sv
`timescale 1ns/1ps
module tmr_match_array_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tick_in = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_match_array dut_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // register offsets from the requirements (R12)
  function automatic logic [7:0] a_cnt(input int ch);   return 8'(8'h40 + 4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_match(input int ch); return 8'(8'h80 + 4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_ctrl(input int ch);  return 8'(8'hC0 + 4 * (ch - 4)); endfunction
  function automatic logic [31:0] sbit(input int ch);   return 32'(1) << ch; endfunction
  function automatic logic [31:0] keep_mask(input int ch); return (ch < 8) ? 32'hFF : 32'h3FF; endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata;
    cyc();
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input logic [4:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      tick_in = m;
      cyc();
    end
    tick_in = '0;
  endtask

  task automatic tick_and_wr(input logic [4:0] m, input logic [7:0] a, input logic [31:0] d);
    tick_in = m; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    tick_in = '0; bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int sel, exp_cnt;
    void'($urandom(32'd2024));
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // reset state
    rd(a_cnt(4), d);  check("R12 reset counter", d, 0);
    rd(a_ctrl(8), d); check("R12 reset control", d, 0);
    rd(8'h14, d);     check("R9 reset status", d, 0);
    check("R10 reset irq", {31'b0, irq}, 0);

    // R1: clock select on channel 4
    wr(a_ctrl(4), 32'h2);
    ticks(5'b00010, 3);
    ticks(5'b00001, 2);
    ticks(5'b11101, 1);
    rd(a_cnt(4), d); check("R1 select 2 counts tick 1", d, 3);
    wr(a_ctrl(4), 32'h6);
    ticks(5'b11111, 2);
    rd(a_cnt(4), d); check("R1 select 6 stopped", d, 3);
    wr(a_ctrl(4), 32'h5);
    ticks(5'b10000, 1);
    rd(a_cnt(4), d); check("R1 select 5 external", d, 4);

    // R2, R3: follower 5 matches on leader 4
    wr(8'h1C, sbit(5));
    wr(a_ctrl(4), 32'h4);
    wr(a_cnt(4), 0);
    wr(a_match(5), 5);
    wr(a_ctrl(5), 0);
    ticks(5'b01000, 5);
    rd(8'h14, d); check("R2 no match before leader reaches 5", d, 0);
    ticks(5'b01000, 1);
    rd(8'h14, d); check("R2 follower match on leader count", d, sbit(5));
    check("R10 irq high with status", {31'b0, irq}, 1);
    rd(a_cnt(5), d); check("R3 follower counter frozen", d, 0);
    wr(8'h14, sbit(5));
    rd(8'h14, d); check("R9 status cleared by write", d, 0);
    check("R10 irq low after clear", {31'b0, irq}, 0);

    // R4, R5: channel 8 clear-on-match, one-shot then periodic
    wr(8'h1C, sbit(8));
    wr(a_ctrl(8), 32'h8C);
    wr(a_match(8), 3);
    wr(a_cnt(8), 0);
    ticks(5'b01000, 4);
    rd(a_cnt(8), d); check("R4 counter cleared on match", d, 0);
    rd(8'h14, d);    check("R9 enabled match sets status", d, sbit(8));
    wr(8'h14, sbit(8));
    ticks(5'b01000, 4);
    rd(a_cnt(8), d); check("R5 one-shot no second clear", d, 4);
    rd(8'h14, d);    check("R5 one-shot no second event", d, 0);
    wr(a_cnt(8), 0);
    ticks(5'b01000, 4);
    rd(8'h14, d);    check("R5 counter write re-arms", d, sbit(8));
    wr(8'h14, sbit(8));
    wr(a_ctrl(8), 32'hCC);
    wr(a_cnt(8), 0);
    ticks(5'b01000, 4);
    wr(8'h14, sbit(8));
    ticks(5'b01000, 4);
    rd(8'h14, d);    check("R5 periodic fires again", d, sbit(8));
    wr(8'h14, sbit(8));

    // R10: match and clear in the same cycle
    ticks(5'b01000, 3);
    tick_and_wr(5'b01000, 8'h14, sbit(8));
    rd(8'h14, d); check("R10 set wins over clear", d, sbit(8));
    check("R10 irq stays high", {31'b0, irq}, 1);
    wr(8'h14, sbit(8));
    check("R10 irq drops", {31'b0, irq}, 0);

    // R11: bus write beats tick
    tick_and_wr(5'b01000, a_cnt(8), 32'd100);
    rd(a_cnt(8), d); check("R11 write wins over tick", d, 100);

    // R6: forced stop on channel 10
    wr(a_ctrl(10), 32'h184);
    wr(a_cnt(10), 7);
    ticks(5'b01000, 3);
    rd(a_cnt(10), d); check("R6 bit 8 stops counter", d, 7);
    wr(a_ctrl(10), 32'h084);
    ticks(5'b01000, 3);
    rd(a_cnt(10), d); check("R6 counts once released", d, 10);

    // R7: control write masks
    wr(a_ctrl(4), 32'hFFFF_FFFF);
    rd(a_ctrl(4), d); check("R7 low group keeps 8 bits", d, keep_mask(4));
    wr(a_ctrl(11), 32'hFFFF_FFFF);
    rd(a_ctrl(11), d); check("R7 high group keeps 10 bits", d, keep_mask(11));
    wr(a_ctrl(4), 0);
    wr(a_ctrl(11), 0);

    // R8: snapshot of the partner counter
    wr(a_ctrl(8), 32'h80);
    wr(a_cnt(8), 32'h1234);
    wr(a_ctrl(9), 32'h200);
    rd(a_cnt(9), d); check("R3 follower 9 counter frozen", d, 0);
    rd(8'h20, d);    check("R8 snapshot of channel 8", d, 32'h1234);
    rd(a_cnt(11), d);
    rd(8'h20, d);    check("R8 no capture without bit 9", d, 32'h1234);
    wr(a_ctrl(11), 32'h200);
    rd(a_cnt(11), d);
    rd(8'h20, d);    check("R8 snapshot of channel 10", d, 32'd10);

    // R12: unmapped offsets and enable readback
    rd(8'h30, d); check("R12 unmapped reads 0", d, 0);
    rd(8'h64, d); check("R12 gap in counter bank reads 0", d, 0);
    rd(8'h1C, d); check("R9 enable readback", d, sbit(8));

    // R1: random tick patterns with random select
    for (int it = 0; it < 6; it++) begin
      sel = 1 + int'($urandom % 5);
      wr(a_ctrl(4), 32'h80 | 32'(sel));
      wr(a_cnt(4), 0);
      exp_cnt = 0;
      for (int c = 0; c < 150; c++) begin
        logic [4:0] m;
        m = 5'($urandom);
        if (m[sel-1]) exp_cnt++;
        ticks(m, 1);
      end
      rd(a_cnt(4), d); check("R1 random tick count", d, 32'(exp_cnt));
    end

    done = 1'b1;
    finish_run();
  end
endmodule